// File: doc/BRIEF.md
# Reset and Deep Power-Down Sequencer

This controller watches the active-low power-down/reset pin of a flash device and decides, on every clock, whether the device is running normally, counting out a possible power-down pulse, sitting in deep power-down, shutting down an interrupted program or erase, or recovering after the pin is released. It drives the qualifiers that the rest of the device uses. These qualifiers tell when reads and writes may start, when the interpreter of commands is held in reset, when the status register takes its reset value and when the data outputs must float.

If the pin falls while a program or erase engine reports busy, the sequencer raises an abort request for a fixed number of cycles. It also gives a one-cycle pulse that marks the target location or block as no longer valid. When that interval ends, the pin level decides between recovery and deep power-down. Both recovery windows are then counted from the end of the interval, not from the pin edge. All timings are parameters in clock cycles.

Top module: `rpd_sequencer`

## Requirements
- R1: After the block reset is released with the pin high, the block runs normally: rd_ok=1, wr_ok=1, pwr_down=0, abort_req=0, ci_reset=0, and sts_value reads 0x80.
- R2: While no operation is busy, a low pin level seen on fewer than MIN_PULSE consecutive clock edges is ignored: rd_ok, wr_ok stay 1 and pwr_down, ci_reset, sts_load stay 0.
- R3: While idle, a low level seen on MIN_PULSE consecutive edges enters deep power-down from the cycle after the MIN_PULSE-th low sample. In that state pwr_down=1, ci_reset=1, rd_ok=0, wr_ok=0 and out_hiz=1.
- R4: Recovery begins on the edge that first samples the pin high in deep power-down. rd_ok is 0 for RD_REC cycles after that edge and 1 from then on.
- R5: wr_ok is 0 for WR_REC cycles after recovery begins, with WR_REC >= RD_REC. It is then 1 and normal operation resumes, so wr_ok never rises before rd_ok.
- R6: In the first cycle of every recovery, sts_load pulses for exactly one cycle so the status register takes sts_value = 0x80. ci_reset holds the command interpreter in read-array mode throughout abort and deep power-down.
- R7: If pe_busy is 1 on the edge that first samples the pin low, abort_req is 1 for exactly ABORT_CYC cycles from the next cycle. invalidate is 1 only in the first of those cycles.
- R8: At the end of the abort interval, the pin level decides the next state. If the pin is high, recovery begins at once. If the pin is low, the block enters deep power-down (pwr_down=1) and stays there until the pin is sampled high.
- R9: After an abort, the recovery of R4 and R5 is counted from the later of the abort end and the first high sample. An early pin release therefore does not shorten the recovery.
- R10: standby=1 only when sel_n=1, pe_busy=0 and the block runs normally. A busy operation keeps the device active while it is deselected. out_hiz = sel_n or not rd_ok.
- R11: A low pin sample during recovery returns the block to deep power-down in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low |
| pd_pin_n | input | 1 | Synchronised power-down/reset pin, active low |
| sel_n | input | 1 | Chip select, active low |
| pe_busy | input | 1 | Program or erase engine busy |
| rd_ok | output | 1 | Reads may start |
| wr_ok | output | 1 | Writes may start |
| pwr_down | output | 1 | Deep power-down, internal circuits off |
| ci_reset | output | 1 | Hold command interpreter in read-array reset |
| abort_req | output | 1 | Abort the running program/erase |
| invalidate | output | 1 | One-cycle pulse: aborted target is invalid |
| sts_load | output | 1 | One-cycle pulse: load status register |
| sts_value | output | 8 | Status reset value, 0x80 |
| out_hiz | output | 1 | Float the data outputs |
| standby | output | 1 | Low-power standby in effect |

## Verification
Random low pulses of width 1 to 14 cycles are applied, each with the engine idle or busy, together with random chip select. These separate the ignored glitch, deep power-down and abort paths. Widths just below, at and above MIN_PULSE locate the glitch threshold. Busy pulses shorter than, equal to and longer than ABORT_CYC show whether recovery is counted from the abort end or from the pin edge. Directed cases cover a low sample during recovery and deselection during a busy operation, which separate R11 and R10 from the normal recovery path.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_PULSE = 3'd1,
        ST_DEEP  = 3'd2,
        ST_ABORT = 3'd3,
        ST_WAKE  = 3'd4
    } rpd_state_e;

    localparam logic [7:0] STAT_RESET = 8'h80;
endpackage

// File: rtl/rpd_core.sv
module rpd_core
    import rpd_pkg::*;
#(
    parameter int MIN_PULSE = 4,
    parameter int ABORT_CYC = 6,
    parameter int WR_REC    = 7,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_pin_n,
    input  logic          pe_busy,
    output rpd_state_e    state_q,
    output logic [CW-1:0] cnt_q,
    output logic          inv_q,
    output logic          ld_q
);
    typedef struct packed {
        rpd_state_e    st;
        logic [CW-1:0] cnt;
        logic          inv;
        logic          ld;
    } core_t;

    localparam logic [CW-1:0] PULSE_LAST = CW'(MIN_PULSE - 1);
    localparam logic [CW-1:0] ABORT_LAST = CW'(ABORT_CYC - 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WR_REC - 1);

    core_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.inv = 1'b0;
        r_d.ld  = 1'b0;
        case (r_q.st)
            ST_RUN: begin
                if (!pd_pin_n) begin
                    if (pe_busy) begin
                        r_d.st  = ST_ABORT;
                        r_d.cnt = '0;
                        r_d.inv = 1'b1;
                    end else begin
                        r_d.st  = ST_PULSE;
                        r_d.cnt = CW'(1);
                    end
                end
            end
            ST_PULSE: begin
                if (pd_pin_n) begin
                    r_d.st = ST_RUN;
                end else if (r_q.cnt == PULSE_LAST) begin
                    r_d.st = ST_DEEP;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_DEEP: begin
                if (pd_pin_n) begin
                    r_d.st  = ST_WAKE;
                    r_d.cnt = '0;
                    r_d.ld  = 1'b1;
                end
            end
            ST_ABORT: begin
                if (r_q.cnt == ABORT_LAST) begin
                    if (pd_pin_n) begin
                        r_d.st  = ST_WAKE;
                        r_d.cnt = '0;
                        r_d.ld  = 1'b1;
                    end else begin
                        r_d.st = ST_DEEP;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_WAKE: begin
                if (!pd_pin_n) begin
                    r_d.st = ST_DEEP;
                end else if (r_q.cnt == WAKE_LAST) begin
                    r_d.st = ST_RUN;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d.st = ST_DEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, cnt: '0, inv: 1'b0, ld: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q = r_q.st;
    assign cnt_q   = r_q.cnt;
    assign inv_q   = r_q.inv;
    assign ld_q    = r_q.ld;

    a_r2_glitch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && pd_pin_n) |=> (state_q == ST_RUN));

    a_r11_wake_relapse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !pd_pin_n) |=> (state_q == ST_DEEP));

    a_r7_inv_single: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q |=> !inv_q);

    a_r8_abort_low_deep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT && cnt_q == ABORT_LAST && !pd_pin_n) |=> (state_q == ST_DEEP));
endmodule

// File: rtl/rpd_outs.sv
module rpd_outs
    import rpd_pkg::*;
#(
    parameter int RD_REC = 3,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rpd_state_e    state_q,
    input  logic [CW-1:0] cnt_q,
    input  logic          inv_q,
    input  logic          ld_q,
    input  logic          sel_n,
    input  logic          pe_busy,
    output logic          rd_ok,
    output logic          wr_ok,
    output logic          pwr_down,
    output logic          ci_reset,
    output logic          abort_req,
    output logic          invalidate,
    output logic          sts_load,
    output logic          out_hiz,
    output logic          standby
);
    localparam logic [CW-1:0] RD_AT = CW'(RD_REC);

    logic running;

    always_comb begin
        running   = (state_q == ST_RUN) || (state_q == ST_PULSE);
        wr_ok     = running;
        rd_ok     = running || (state_q == ST_WAKE && cnt_q >= RD_AT);
        pwr_down  = (state_q == ST_DEEP);
        abort_req = (state_q == ST_ABORT);
        ci_reset  = (state_q == ST_DEEP) || (state_q == ST_ABORT);
        invalidate = inv_q;
        sts_load  = ld_q;
        out_hiz   = sel_n || !rd_ok;
        standby   = sel_n && !pe_busy && running;
    end

    a_r3_deep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!rd_ok && !wr_ok && out_hiz));

    a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> rd_ok);

    a_r10_busy_stays_active: assert property (@(posedge clk) disable iff (!rst_n)
        pe_busy |-> !standby);

    a_r7_inv_in_abort: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> abort_req);

    a_r6_load_once: assert property (@(posedge clk) disable iff (!rst_n)
        sts_load |=> !sts_load);
endmodule

// File: rtl/rpd_sequencer.sv
module rpd_sequencer
    import rpd_pkg::*;
#(
    parameter int MIN_PULSE = 4,
    parameter int ABORT_CYC = 6,
    parameter int RD_REC    = 3,
    parameter int WR_REC    = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_pin_n,
    input  logic       sel_n,
    input  logic       pe_busy,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       pwr_down,
    output logic       ci_reset,
    output logic       abort_req,
    output logic       invalidate,
    output logic       sts_load,
    output logic [7:0] sts_value,
    output logic       out_hiz,
    output logic       standby
);
    localparam int MAX_A = (MIN_PULSE > ABORT_CYC) ? MIN_PULSE : ABORT_CYC;
    localparam int MAX_V = (MAX_A > WR_REC) ? MAX_A : WR_REC;
    localparam int CW    = $clog2(MAX_V + 1);

    rpd_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          inv_q;
    logic          ld_q;

    rpd_core #(
        .MIN_PULSE (MIN_PULSE),
        .ABORT_CYC (ABORT_CYC),
        .WR_REC    (WR_REC),
        .CW        (CW)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_pin_n (pd_pin_n),
        .pe_busy  (pe_busy),
        .state_q  (state_q),
        .cnt_q    (cnt_q),
        .inv_q    (inv_q),
        .ld_q     (ld_q)
    );

    rpd_outs #(
        .RD_REC (RD_REC),
        .CW     (CW)
    ) u_outs (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .cnt_q      (cnt_q),
        .inv_q      (inv_q),
        .ld_q       (ld_q),
        .sel_n      (sel_n),
        .pe_busy    (pe_busy),
        .rd_ok      (rd_ok),
        .wr_ok      (wr_ok),
        .pwr_down   (pwr_down),
        .ci_reset   (ci_reset),
        .abort_req  (abort_req),
        .invalidate (invalidate),
        .sts_load   (sts_load),
        .out_hiz    (out_hiz),
        .standby    (standby)
    );

    assign sts_value = STAT_RESET;
endmodule

// File: tb/rpd_sequencer_bench.sv
module rpd_sequencer_bench;
    localparam int MIN_PULSE = 4;
    localparam int ABORT_CYC = 6;
    localparam int RD_REC    = 3;
    localparam int WR_REC    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_pin_n = 1'b1;
    logic sel_n = 1'b0;
    logic pe_busy = 1'b0;
    logic rd_ok, wr_ok, pwr_down, ci_reset, abort_req, invalidate, sts_load;
    logic out_hiz, standby;
    logic [7:0] sts_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rpd_sequencer #(
        .MIN_PULSE (MIN_PULSE),
        .ABORT_CYC (ABORT_CYC),
        .RD_REC    (RD_REC),
        .WR_REC    (WR_REC)
    ) u_rpd_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_pin_n   (pd_pin_n),
        .sel_n      (sel_n),
        .pe_busy    (pe_busy),
        .rd_ok      (rd_ok),
        .wr_ok      (wr_ok),
        .pwr_down   (pwr_down),
        .ci_reset   (ci_reset),
        .abort_req  (abort_req),
        .invalidate (invalidate),
        .sts_load   (sts_load),
        .sts_value  (sts_value),
        .out_hiz    (out_hiz),
        .standby    (standby)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // cycle where recovery starts, -1 when the pulse is ignored
    function automatic int wake_start(input int width, input bit busy);
        if (busy) return (width > ABORT_CYC) ? width : ABORT_CYC;
        return (width >= MIN_PULSE) ? width : -1;
    endfunction

    function automatic bit exp_ok(input int k, input int s, input int hs, input int lim);
        if (s < 0 || k < hs) return 1'b1;
        if (k < s) return 1'b0;
        return (k - s) >= lim;
    endfunction

    task automatic run_case(input int width, input bit busy, input string tag);
        int s, hs, ps, last;
        bit e_rd, e_wr, e_pd, e_ci;
        s    = wake_start(width, busy);
        hs   = busy ? 0 : MIN_PULSE - 1;
        ps   = busy ? ABORT_CYC : MIN_PULSE - 1;
        last = (s < 0) ? width + 3 : s + WR_REC + 2;
        @(negedge clk);
        pd_pin_n = 1'b0;
        pe_busy  = busy;
        sel_n    = 1'($urandom_range(0, 1));
        for (int k = 0; k <= last; k++) begin
            @(posedge clk);
            @(negedge clk);
            e_rd = exp_ok(k, s, hs, RD_REC);
            e_wr = exp_ok(k, s, hs, WR_REC);
            e_pd = (s >= 0) && (k >= ps) && (k < s);
            e_ci = (s >= 0) && (k >= hs) && (k < s);
            if (s < 0) begin
                check({tag, " R2 rd_ok"}, 8'(rd_ok), 8'(e_rd));
                check({tag, " R2 ci_reset"}, 8'(ci_reset), 8'(e_ci));
            end else begin
                check({tag, " R4/R9 rd_ok"}, 8'(rd_ok), 8'(e_rd));
                check({tag, " R3/R8 ci_reset"}, 8'(ci_reset), 8'(e_ci));
            end
            check({tag, " R5 wr_ok"}, 8'(wr_ok), 8'(e_wr));
            check({tag, " R3/R8 pwr_down"}, 8'(pwr_down), 8'(e_pd));
            check({tag, " R7 abort_req"}, 8'(abort_req), 8'(busy && k < ABORT_CYC));
            check({tag, " R7 invalidate"}, 8'(invalidate), 8'(busy && k == 0));
            check({tag, " R6 sts_load"}, 8'(sts_load), 8'(k == s));
            check({tag, " R10 out_hiz"}, 8'(out_hiz), 8'(sel_n || !e_rd));
            check({tag, " R10 standby"}, 8'(standby), 8'(sel_n && !pe_busy && e_wr));
            pd_pin_n = (k + 1 < width) ? 1'b0 : 1'b1;
            pe_busy  = 1'b0;
            sel_n    = 1'($urandom_range(0, 1));
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_ok", 8'(rd_ok), 8'd1);
        check("R1 wr_ok", 8'(wr_ok), 8'd1);
        check("R1 pwr_down", 8'(pwr_down), 8'd0);
        check("R1 abort_req", 8'(abort_req), 8'd0);
        check("R1 ci_reset", 8'(ci_reset), 8'd0);
        check("R1 sts_value", sts_value, 8'h80);

        // directed boundaries
        run_case(MIN_PULSE - 1, 1'b0, "idle-short");
        run_case(MIN_PULSE, 1'b0, "idle-min");
        run_case(1, 1'b1, "busy-1");
        run_case(ABORT_CYC, 1'b1, "busy-eq");
        run_case(ABORT_CYC + 1, 1'b1, "busy-long");
        run_case(ABORT_CYC + 5, 1'b1, "busy-longer");

        // R10: deselected while busy stays active
        @(negedge clk);
        sel_n = 1'b1;
        pe_busy = 1'b1;
        #1;
        check("R10 standby busy", 8'(standby), 8'd0);
        check("R10 out_hiz deselect", 8'(out_hiz), 8'd1);
        pe_busy = 1'b0;
        #1;
        check("R10 standby idle", 8'(standby), 8'd1);
        sel_n = 1'b0;

        // R11: low sample during recovery returns to deep power-down
        @(negedge clk);
        pd_pin_n = 1'b0;
        repeat (MIN_PULSE + 1) @(posedge clk);
        @(negedge clk);
        check("R11 deep entered", 8'(pwr_down), 8'd1);
        pd_pin_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 wake sts_load", 8'(sts_load), 8'd1);
        check("R11 wake pwr_down", 8'(pwr_down), 8'd0);
        pd_pin_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R11 relapse pwr_down", 8'(pwr_down), 8'd1);
        check("R11 relapse rd_ok", 8'(rd_ok), 8'd0);
        pd_pin_n = 1'b1;
        repeat (WR_REC + 1) @(posedge clk);
        @(negedge clk);
        check("R11 recovered wr_ok", 8'(wr_ok), 8'd1);

        // random pulses
        for (int i = 0; i < 40; i++) begin
            run_case(int'($urandom_range(1, 14)), 1'($urandom_range(0, 1)), "rand");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule